// File: doc/BRIEF.md
# Two-Slot Receive Frame Buffer with Destination Filter

This block sits on the receive side of an Ethernet-style MAC. Frames arrive as a byte stream qualified by `in_valid`, with `in_sof` marking the first byte and `in_eof` the last. The block looks at the first six bytes (the destination address) and keeps a frame when it is group-addressed or when those bytes equal the station address. Kept frames go into one of two storage slots, the *current* slot.

When a frame ends, the slot's full flag is set. An interrupt pulse may also be raised. When ping-pong operation is on, the current slot then swaps to the other slot. A frame that starts while the current slot is still full is lost as a whole. Software reads the stored bytes through a word-wide read port. It hands a slot back by writing a 0 into that slot's full bit.

The control FSM has four states:

- `ST_IDLE` waits for a start byte.
- `ST_HDR` collects destination bytes 1 to 5 while comparing them.
- `ST_BODY` stores the rest of an accepted frame.
- `ST_DROP` discards bytes up to the end marker.

Its transitions are:

- start byte with a free slot: go to `ST_HDR`.
- start byte with a full slot: go to `ST_DROP`.
- sixth byte with a passing address: go to `ST_BODY`.
- sixth byte with a failing address: go to `ST_DROP`.
- end byte in `ST_BODY`: commit, then go to `ST_IDLE`.
- end byte in `ST_HDR` or `ST_DROP`: go to `ST_IDLE`.
- start byte in any state: restart with a new frame.

Top module: `rx_pingpong_filter`

## Requirements
- R1: After reset, `buf_full` is 00, `cur_buf` is 0, both interrupt enables are 0, and `rx_irq` and `rx_trunc` are low.
- R2: An accepted frame's byte k is stored in the current slot at word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4). Word w of slot s is read on `rd_data` one clock after `rd_sel`=s and `rd_word`=w are applied. The station address is sent first byte first: byte 0 is `station_mac[47:40]`.
- R3: A frame whose first byte has bit 0 clear is discarded if any of its first six bytes differs from the station address. A discarded frame sets no flag, raises no pulse and leaves `cur_buf` unchanged.
- R4: A frame whose first byte has bit 0 set (group address) is accepted whatever its other address bytes are.
- R5: On the clock edge that takes the end byte of an accepted frame, the current slot's full flag (control bit 0) is set.
- R6: `rx_irq` is high for exactly one cycle after each commit, but only when slot 0's interrupt enable (control bit 3) and `global_irq_en` were both 1 at that edge. This holds whichever slot took the frame.
- R7: After a commit, `cur_buf` toggles when `pingpong_en` is 1 and stays unchanged when it is 0.
- R8: A frame whose start byte arrives while the current slot is full is lost. It writes no byte, sets no flag and raises no pulse.
- R9: A control write (`ctl_we`, `ctl_sel` picks the slot) loads the interrupt enable from `ctl_wr_ie`. It clears the full flag when `ctl_wr_status`=0 and leaves the flag alone when it is 1. `ctl_rdata` shows the selected slot's full flag at bit 0, its enable at bit 3, and zeros elsewhere.
- R10: The fullness check at a start byte uses the flag value from before that edge. A release written in the same cycle as the start byte does not save that frame.
- R11: Bytes beyond `BUF_BYTES` (2044) are not stored. The frame is still committed, and `rx_trunc` pulses for one cycle together with the full flag.
- R12: A frame that ends before its sixth byte is discarded. A start byte seen in the middle of a frame abandons that frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| pingpong_en | input | 1 | Swap slots after each commit |
| global_irq_en | input | 1 | Global interrupt enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 1 | Slot addressed by control read and write |
| ctl_wr_status | input | 1 | Written full bit (0 releases the slot) |
| ctl_wr_ie | input | 1 | Written interrupt enable |
| ctl_rdata | output | 4 | Selected slot: bit 3 enable, bit 0 full |
| rd_sel | input | 1 | Slot for the buffer read |
| rd_word | input | WORD_W (9) | Word index for the buffer read |
| rd_data | output | 32 | Read word, one cycle latency |
| buf_full | output | 2 | Full flags of slots 1 and 0 |
| cur_buf | output | 1 | Slot that takes the next frame |
| rx_irq | output | 1 | Receive interrupt pulse |
| rx_trunc | output | 1 | Truncation pulse |

## Verification
Two pairs of functions can coincide, and the bench provokes both by driving a release write on the same clock as a frame byte. In the first pair, a frame's end byte commits into one slot while software frees the other slot. Both flag changes must land on that single edge, and the pulse and slot swap must be unaffected. In the second pair, software frees the current slot on the very cycle a start byte arrives. The frame must still be lost, since the check uses the flag from before the edge, and the slot must then read empty. A behavioural frame-level model follows every byte and write, and its flags, slot index and pulses are compared with the ports on every clock.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_DROP
    } rx_state_e;

    localparam int ADDR_BYTES = 6;
endpackage

// File: rtl/rxpp_addr_match.sv
module rxpp_addr_match #(
    parameter int N_BYTES = 6
) (
    input  logic [2:0]           idx,
    input  logic [7:0]           data,
    input  logic [8*N_BYTES-1:0] mac,
    output logic                 hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (int'(idx) == i) begin
                hit = (data == mac[8*(N_BYTES-1-i) +: 8]);
            end
        end
    end
endmodule

// File: rtl/rxpp_dual_ram.sv
module rxpp_dual_ram #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wslot,
    input  logic [WORD_W+1:0] wbyte,
    input  logic [7:0]        wdata,
    input  logic              rslot,
    input  logic [WORD_W-1:0] rword,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 2 ** (WORD_W + 1);

    logic [31:0] mem [DEPTH];
    logic [WORD_W:0] widx;
    logic [1:0]      lane;

    assign widx = {wslot, wbyte[WORD_W+1:2]};
    assign lane = wbyte[1:0];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx][8*lane +: 8] <= wdata;
        end
        rdata <= mem[{rslot, rword}];
    end
endmodule

// File: rtl/rxpp_flags.sv
module rxpp_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       commit_trunc,
    input  logic       pp_en,
    input  logic       gie,
    input  logic       we,
    input  logic       sel,
    input  logic       wr_status,
    input  logic       wr_ie,
    output logic [1:0] full,
    output logic [1:0] ie,
    output logic       cur,
    output logic       irq,
    output logic       trunc
);
    for (genvar b = 0; b < 2; b++) begin : g_slot
        logic full_q;
        logic ie_q;
        logic hit_we;

        assign hit_we = we && (sel == 1'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                ie_q   <= 1'b0;
            end else begin
                full_q <= (full_q && !(hit_we && !wr_status)) || (commit && cur == 1'(b));
                if (hit_we) begin
                    ie_q <= wr_ie;
                end
            end
        end

        assign full[b] = full_q;
        assign ie[b]   = ie_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= 1'b0;
            irq   <= 1'b0;
            trunc <= 1'b0;
        end else begin
            if (commit && pp_en) begin
                cur <= ~cur;
            end
            irq   <= commit && ie[0] && gie;
            trunc <= commit && commit_trunc;
        end
    end
endmodule

// File: rtl/rx_pingpong_filter.sv
module rx_pingpong_filter
    import rxpp_pkg::*;
#(
    parameter int  BUF_BYTES = 2044,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1),
    localparam int WORD_W    = CNT_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [47:0]       station_mac,
    input  logic              pingpong_en,
    input  logic              global_irq_en,
    input  logic              ctl_we,
    input  logic              ctl_sel,
    input  logic              ctl_wr_status,
    input  logic              ctl_wr_ie,
    output logic [3:0]        ctl_rdata,
    input  logic              rd_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    output logic [1:0]        buf_full,
    output logic              cur_buf,
    output logic              rx_irq,
    output logic              rx_trunc
);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(BUF_BYTES);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             miss_q, miss_d;
    logic             grp_q, grp_d;
    logic             trunc_q, trunc_d;
    logic             wr_en;
    logic [CNT_W-1:0] wr_pos;
    logic             commit;
    logic             commit_trunc;
    logic             byte_hit;
    logic             hdr_pass;
    logic [2:0]       cmp_idx;
    logic [1:0]       buf_ie;

    assign cmp_idx = in_sof ? 3'd0 : cnt_q[2:0];

    rxpp_addr_match #(.N_BYTES(ADDR_BYTES)) u_match (
        .idx  (cmp_idx),
        .data (in_data),
        .mac  (station_mac),
        .hit  (byte_hit)
    );

    rxpp_dual_ram #(.WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .wslot (cur_buf),
        .wbyte (wr_pos),
        .wdata (in_data),
        .rslot (rd_sel),
        .rword (rd_word),
        .rdata (rd_data)
    );

    rxpp_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_trunc (commit_trunc),
        .pp_en        (pingpong_en),
        .gie          (global_irq_en),
        .we           (ctl_we),
        .sel          (ctl_sel),
        .wr_status    (ctl_wr_status),
        .wr_ie        (ctl_wr_ie),
        .full         (buf_full),
        .ie           (buf_ie),
        .cur          (cur_buf),
        .irq          (rx_irq),
        .trunc        (rx_trunc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            miss_q  <= 1'b0;
            grp_q   <= 1'b0;
            trunc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            miss_q  <= miss_d;
            grp_q   <= grp_d;
            trunc_q <= trunc_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        miss_d       = miss_q;
        grp_d        = grp_q;
        trunc_d      = trunc_q;
        wr_en        = 1'b0;
        wr_pos       = cnt_q;
        commit       = 1'b0;
        hdr_pass     = grp_q || !(miss_q || !byte_hit);
        commit_trunc = (state_q == ST_BODY) && (trunc_q || cnt_q == CAP);
        if (in_valid) begin
            if (in_sof) begin
                cnt_d   = CNT_W'(1);
                grp_d   = in_data[0];
                miss_d  = !byte_hit;
                trunc_d = 1'b0;
                if (buf_full[cur_buf]) begin
                    state_d = in_eof ? ST_IDLE : ST_DROP;
                end else begin
                    wr_en   = 1'b1;
                    wr_pos  = '0;
                    state_d = in_eof ? ST_IDLE : ST_HDR;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_HDR: begin
                        wr_en  = 1'b1;
                        cnt_d  = cnt_q + 1'b1;
                        miss_d = miss_q || !byte_hit;
                        if (cnt_q == LAST_HDR) begin
                            if (in_eof) begin
                                commit  = hdr_pass;
                                state_d = ST_IDLE;
                            end else begin
                                state_d = hdr_pass ? ST_BODY : ST_DROP;
                            end
                        end else if (in_eof) begin
                            state_d = ST_IDLE;
                        end
                    end
                    ST_BODY: begin
                        if (cnt_q < CAP) begin
                            wr_en = 1'b1;
                            cnt_d = cnt_q + 1'b1;
                        end else begin
                            trunc_d = 1'b1;
                        end
                        if (in_eof) begin
                            commit  = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end
                    ST_DROP: begin
                        if (in_eof) begin
                            state_d = ST_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        ctl_rdata    = '0;
        ctl_rdata[0] = buf_full[ctl_sel];
        ctl_rdata[3] = buf_ie[ctl_sel];
    end
endmodule

// File: rtl/rx_pingpong_filter_chk.sv
module rx_pingpong_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pingpong_en,
    input logic       global_irq_en,
    input logic       ctl_we,
    input logic       ctl_sel,
    input logic       ctl_wr_status,
    input logic [1:0] buf_full,
    input logic [1:0] buf_ie,
    input logic       cur_buf,
    input logic       rx_irq,
    input logic       rx_trunc
);
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ($past(global_irq_en) && $past(buf_ie[0])));

    p_irq_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ($countones(buf_full & ~$past(buf_full)) == 1));

    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_buf != $past(cur_buf)) |-> $past(pingpong_en));

    p_set0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full[0]) |-> ($past(cur_buf) == 1'b0));

    p_set1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full[1]) |-> ($past(cur_buf) == 1'b1));

    p_release0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full[0]) |-> ($past(ctl_we) && !$past(ctl_sel) && !$past(ctl_wr_status)));

    p_release1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full[1]) |-> ($past(ctl_we) && $past(ctl_sel) && !$past(ctl_wr_status)));

    p_trunc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trunc |-> ($countones(buf_full & ~$past(buf_full)) == 1));
endmodule

bind rx_pingpong_filter rx_pingpong_filter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pingpong_en   (pingpong_en),
    .global_irq_en (global_irq_en),
    .ctl_we        (ctl_we),
    .ctl_sel       (ctl_sel),
    .ctl_wr_status (ctl_wr_status),
    .buf_full      (buf_full),
    .buf_ie        (buf_ie),
    .cur_buf       (cur_buf),
    .rx_irq        (rx_irq),
    .rx_trunc      (rx_trunc)
);

// File: tb/rx_pingpong_filter_test.sv
module rx_pingpong_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 2044;
    localparam int WW         = 9;
    localparam logic [47:0] MAC   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = '0;
    logic pingpong_en = 1'b1, global_irq_en = 1'b1;
    logic ctl_we = 0, ctl_sel = 0, ctl_wr_status = 0, ctl_wr_ie = 0;
    logic [3:0] ctl_rdata;
    logic rd_sel = 0;
    logic [WW-1:0] rd_word = '0;
    logic [31:0] rd_data;
    logic [1:0] buf_full;
    logic cur_buf, rx_irq, rx_trunc;

    int checks = 0, errors = 0;
    bit done = 0, running = 0;
    logic [7:0] fr[$];

    logic [7:0] mbuf [2][2048];
    logic [1:0] m_full = '0, m_ie = '0;
    logic m_cur = 0, m_irq = 0, m_trunc = 0;
    bit m_active = 0, m_lost = 0, m_miss = 0, m_grp = 0, m_pass = 0, m_commit = 0;
    logic [1:0] m_oie;
    int m_pos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pingpong_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .station_mac(MAC), .pingpong_en(pingpong_en),
        .global_irq_en(global_irq_en), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wr_status(ctl_wr_status), .ctl_wr_ie(ctl_wr_ie), .ctl_rdata(ctl_rdata),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data), .buf_full(buf_full),
        .cur_buf(cur_buf), .rx_irq(rx_irq), .rx_trunc(rx_trunc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // frame-level reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = '0; m_ie = '0; m_cur = 0; m_irq = 0; m_trunc = 0; m_active = 0;
        end else begin
            m_oie = m_ie; m_commit = 0; m_irq = 0; m_trunc = 0;
            if (in_valid) begin
                if (in_sof) begin
                    m_active = 1; m_pos = 0; m_lost = m_full[m_cur];
                    m_miss = 0; m_grp = in_data[0]; m_pass = 0;
                end
                if (m_active) begin
                    if (m_pos < 6 && in_data != MAC[8*(5-m_pos) +: 8]) m_miss = 1;
                    if (!m_lost && (m_pos < 6 || m_pass) && m_pos < CAP) mbuf[m_cur][m_pos] = in_data;
                    if (m_pos == 5) m_pass = m_grp || !m_miss;
                    m_pos++;
                    if (in_eof) begin
                        m_commit = !m_lost && m_pos >= 6 && m_pass;
                        m_active = 0;
                    end
                end
            end
            if (ctl_we) begin
                if (!ctl_wr_status) m_full[ctl_sel] = 1'b0;
                m_ie[ctl_sel] = ctl_wr_ie;
            end
            if (m_commit) begin
                m_full[m_cur] = 1'b1;
                m_irq = m_oie[0] && global_irq_en;
                m_trunc = (m_pos > CAP);
                if (pingpong_en) m_cur = ~m_cur;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running && !done) begin
            chk("R5/R8/R9 model full", {30'd0, buf_full}, {30'd0, m_full});
            chk("R7 model cur", {31'd0, cur_buf}, {31'd0, m_cur});
            chk("R6 model irq", {31'd0, rx_irq}, {31'd0, m_irq});
            chk("R11 model trunc", {31'd0, rx_trunc}, {31'd0, m_trunc});
        end
    end

    task automatic mk(input logic [47:0] dst, input int len, input int seed);
        fr.delete();
        for (int i = 0; i < len; i++) begin
            if (i < 6) fr.push_back(dst[8*(5-i) +: 8]);
            else fr.push_back(8'(i * 7 + seed));
        end
    endtask

    task automatic send(input int clr_at, input bit clr_sel, input bit clr_ie, input bit with_eof);
        for (int i = 0; i < fr.size(); i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_data = fr[i];
            in_eof = with_eof && (i == fr.size() - 1);
            if (i == clr_at) begin
                ctl_we = 1; ctl_sel = clr_sel; ctl_wr_status = 0; ctl_wr_ie = clr_ie;
            end else begin
                ctl_we = 0;
            end
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; ctl_we = 0;
    endtask

    task automatic ctl_write(input bit sel, input bit st, input bit ie);
        @(negedge clk);
        ctl_we = 1; ctl_sel = sel; ctl_wr_status = st; ctl_wr_ie = ie;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic read_cmp(input string tag, input bit s, input int w);
        @(negedge clk);
        rd_sel = s; rd_word = WW'(w);
        @(negedge clk);
        chk(tag, rd_data, {mbuf[s][4*w+3], mbuf[s][4*w+2], mbuf[s][4*w+1], mbuf[s][4*w]});
    endtask

    task automatic expect_after(input string tag, input logic [1:0] f, input bit c, input bit irq);
        chk({tag, " full"}, {30'd0, buf_full}, {30'd0, f});
        chk({tag, " cur"}, {31'd0, cur_buf}, {31'd0, c});
        chk({tag, " irq"}, {31'd0, rx_irq}, {31'd0, irq});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 full", {30'd0, buf_full}, 32'd0);
        chk("R1 cur", {31'd0, cur_buf}, 32'd0);
        chk("R1 pulses", {30'd0, rx_irq, rx_trunc}, 32'd0);
        chk("R1 ctl", {28'd0, ctl_rdata}, 32'd0);
        rst_n = 1; running = 1;
        @(negedge clk);
        chk("R1 after release", {29'd0, buf_full, cur_buf}, 32'd0);

        ctl_write(0, 1, 1);
        chk("R9 enable set, status kept", {28'd0, ctl_rdata}, 32'h8);

        mk(MAC, 20, 3); send(-1, 0, 0, 1);
        expect_after("R2/R5/R6/R7 unicast", 2'b01, 1, 1);
        read_cmp("R2 word0", 0, 0);
        chk("R2 word0 const", rd_data, 32'h3322_1102);
        read_cmp("R2 word4", 0, 4);

        mk(OTHER, 20, 5); send(-1, 0, 0, 1);
        expect_after("R3 mismatch", 2'b01, 1, 0);

        mk(BCAST, 10, 9); send(-1, 0, 0, 1);
        expect_after("R4/R6 group to slot1", 2'b11, 0, 1);
        read_cmp("R4 slot1 word2", 1, 2);

        mk(MAC, 12, 11); send(-1, 0, 0, 1);
        expect_after("R8 lost", 2'b11, 0, 0);
        read_cmp("R8 slot0 word0 kept", 0, 0);
        read_cmp("R8 slot0 word2 kept", 0, 2);

        ctl_write(0, 0, 1);
        chk("R9 release slot0", {30'd0, buf_full}, 32'd2);
        ctl_write(1, 1, 0);
        chk("R9 status1 keeps flag", {30'd0, buf_full}, 32'd2);
        @(negedge clk); ctl_sel = 1;
        #1 chk("R9 ctl read slot1", {28'd0, ctl_rdata}, 32'h1);

        mk(MAC, 5, 13); send(-1, 0, 0, 1);
        expect_after("R12 runt", 2'b10, 0, 0);

        // commit into slot0 and release of slot1 on the same edge
        mk(MAC, 8, 15); send(7, 1, 0, 1);
        expect_after("R5/R9 commit with release", 2'b01, 1, 1);

        mk(BCAST, 8, 17); send(-1, 0, 0, 1);
        expect_after("R7 to slot1", 2'b11, 0, 1);
        // release of current slot on the start byte's edge
        mk(MAC, 8, 19); send(0, 0, 1, 1);
        expect_after("R10 release at start", 2'b10, 0, 0);

        ctl_write(0, 1, 0);
        mk(MAC, 8, 21); send(-1, 0, 0, 1);
        expect_after("R6 slot0 enable off", 2'b11, 1, 0);
        ctl_write(0, 0, 1); ctl_write(1, 0, 0);
        global_irq_en = 0;
        mk(BCAST, 8, 23); send(-1, 0, 0, 1);
        expect_after("R6 global off", 2'b10, 0, 0);
        global_irq_en = 1;

        ctl_write(1, 0, 0);
        pingpong_en = 0;
        mk(MAC, 9, 25); send(-1, 0, 0, 1);
        expect_after("R7 no swap", 2'b01, 0, 1);
        mk(MAC, 9, 27); send(-1, 0, 0, 1);
        expect_after("R7/R8 same slot full", 2'b01, 0, 0);
        ctl_write(0, 0, 1);
        pingpong_en = 1;

        mk(BCAST, 2050, 29); send(-1, 0, 0, 1);
        chk("R11 trunc pulse", {31'd0, rx_trunc}, 32'd1);
        expect_after("R11 commit", 2'b01, 1, 1);
        @(negedge clk);
        chk("R11 trunc one cycle", {31'd0, rx_trunc}, 32'd0);
        read_cmp("R11 last word", 0, 510);
        read_cmp("R11 first word", 0, 0);

        mk(MAC, 10, 31); send(-1, 0, 0, 0);
        mk(BCAST, 9, 33); send(-1, 0, 0, 1);
        expect_after("R12 restart", 2'b11, 0, 1);
        read_cmp("R12 restarted word1", 1, 1);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule